// File: doc/BRIEF.md
# Translation Entry Write Checker

This block owns the entry storage of a set-associative translation buffer built from several independent arrays, and guards every write into it. A write command names an array, a way and a set. The entry contents come from a bank of staging fields: a valid flag, a 4-bit page size code, a translation ID, a 64-bit effective page number and two 32-bit real address words. Before the entry is committed, the block checks two things. The addressed slot must exist. When the entry is marked valid and the array allows variable page sizes, the requested size must be one that the array supports. If either check fails, the write is dropped and a one-cycle invalid-operation strobe is raised.

Each array has a row in a small configuration table. The row gives the number of ways that exist, whether page sizes are variable, a 16-bit bitmap of legal size codes and a minimum size code. For an array with a fixed page size, the staged size is ignored and the array's minimum size is stored in its place. A read command returns the stored entry one cycle later. A read of a slot that does not exist returns all zeros instead of faulting.

Top module: `tlb_wr_validator`

## Requirements
- R1: After reset, `wr_done`, `wr_exc` and `rd_valid` are low, and every existing slot reads back with all fields zero.
- R2: A write to an existing slot that passes the size check raises `wr_done` for exactly the cycle after the command, keeps `wr_exc` low, and a later read returns the staged fields.
- R3: A write whose array index is not below `N_ARR`, or whose way is not below that array's configured way count, raises `wr_exc` for the cycle after the command, never raises `wr_done`, and leaves every stored entry unchanged.
- R4: When the staged valid flag is 1 and the array's variable-size flag is 1, a size code N whose bit N in the array's 16-bit bitmap is 0 causes `wr_exc`, and the target entry keeps its previous contents.
- R5: When the staged valid flag is 0, the bitmap is not consulted, and the write commits whatever the size code.
- R6: For an array whose variable-size flag is 0, the bitmap is not consulted, and the stored size equals the array's configured minimum size code, whatever size was staged.
- R7: The stored real address is the upper staged word in bits 63:32 joined with the lower staged word in bits 31:0.
- R8: The stored effective page number is bits 31:0 of the 64-bit staged value.
- R9: A read command drives `rd_valid` high in the next cycle, with that slot's contents on the read outputs.
- R10: A read of a slot that does not exist, judged by the same rule as R3, returns all read fields zero, including the valid bit.
- R11: Each write command produces exactly one one-cycle pulse, on either `wr_done` or `wr_exc` and never on both. Back-to-back commands each get their own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write command strobe |
| cmd_rd | input | 1 | Read command strobe |
| cmd_arr | input | ARR_W (2) | Target array index |
| cmd_way | input | WAY_W (2) | Target way |
| cmd_set | input | SET_W (2) | Target set |
| stg_valid | input | 1 | Staged valid flag |
| stg_size | input | 4 | Staged page size code |
| stg_tid | input | 8 | Staged translation ID |
| stg_epn | input | 64 | Staged effective page number |
| stg_ra_hi | input | 32 | Staged real address, upper word |
| stg_ra_lo | input | 32 | Staged real address, lower word |
| cfg_ways | input | N_ARR*CW (6) | Way count of each array, CW bits per array |
| cfg_var | input | N_ARR (2) | Variable page size allowed, one bit per array |
| cfg_sizes | input | N_ARR*16 (32) | Legal size bitmap of each array |
| cfg_min | input | N_ARR*4 (8) | Minimum size code of each array |
| wr_done | output | 1 | Write committed pulse |
| wr_exc | output | 1 | Invalid-operation pulse |
| rd_valid | output | 1 | Read data present |
| rd_vbit | output | 1 | Read entry valid flag |
| rd_size | output | 4 | Read entry size code |
| rd_tid | output | 8 | Read entry translation ID |
| rd_epn | output | 32 | Read entry effective page number |
| rd_ra | output | 64 | Read entry real address |

## Verification
A wrong slot-existence or size decision shows up on `wr_done` or `wr_exc` in the cycle right after the write command. A write that corrupts storage, by landing in the wrong slot or by committing despite an exception, only becomes visible when that slot is read. Every write is therefore followed by a read-back, one cycle later at the earliest, of the target slot. Slots that should have kept their old contents are read back as well, so that a stray commit cannot hide.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
   localparam int SZ_W  = 4;
   localparam int MAP_W = 1 << SZ_W;
   localparam int TID_W = 8;
   localparam int EPN_W = 32;
   localparam int RA_W  = 64;

   typedef struct packed {
      logic              vld;
      logic [SZ_W-1:0]   size;
      logic [TID_W-1:0]  tid;
      logic [EPN_W-1:0]  epn;
      logic [RA_W-1:0]   ra;
   } tlbw_entry_t;
endpackage

// File: rtl/tlbw_slot_chk.sv
module tlbw_slot_chk #(
   parameter int N_ARR    = 2,
   parameter int MAX_WAYS = 4,
   localparam int ARR_W   = $clog2(N_ARR) + 1,
   localparam int WAY_W   = $clog2(MAX_WAYS),
   localparam int CW      = $clog2(MAX_WAYS + 1)
) (
   input  logic [ARR_W-1:0]    arr_i,
   input  logic [WAY_W-1:0]    way_i,
   input  logic [N_ARR*CW-1:0] ways_cfg_i,
   output logic                exists_o
);
   always_comb begin
      exists_o = 1'b0;
      for (int i = 0; i < N_ARR; i++) begin
         if (arr_i == ARR_W'(i))
            exists_o = ({1'b0, way_i} < (WAY_W+1)'(ways_cfg_i[i*CW +: CW]));
      end
   end
endmodule

// File: rtl/tlbw_size_ctl.sv
module tlbw_size_ctl
   import tlbw_pkg::*;
(
   input  logic             vld_i,
   input  logic             var_i,
   input  logic [MAP_W-1:0] map_i,
   input  logic [SZ_W-1:0]  min_i,
   input  logic [SZ_W-1:0]  size_i,
   output logic             ok_o,
   output logic [SZ_W-1:0]  size_o
);
   // The bitmap only gates valid entries of variable-size arrays.
   assign ok_o   = !(vld_i && var_i) || map_i[size_i];
   assign size_o = var_i ? size_i : min_i;
endmodule

// File: rtl/tlbw_store.sv
module tlbw_store
   import tlbw_pkg::*;
#(
   parameter int N_ARR    = 2,
   parameter int MAX_WAYS = 4,
   parameter int SETS     = 4,
   localparam int AIDX_W  = (N_ARR > 1) ? $clog2(N_ARR) : 1,
   localparam int WAY_W   = $clog2(MAX_WAYS),
   localparam int SET_W   = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AIDX_W-1:0] w_arr,
   input  logic [WAY_W-1:0]  w_way,
   input  logic [SET_W-1:0]  w_set,
   input  tlbw_entry_t       din,
   input  logic [AIDX_W-1:0] r_arr,
   input  logic [WAY_W-1:0]  r_way,
   input  logic [SET_W-1:0]  r_set,
   output tlbw_entry_t       dout
);
   tlbw_entry_t mem [N_ARR][MAX_WAYS][SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < N_ARR; a++)
            for (int w = 0; w < MAX_WAYS; w++)
               for (int s = 0; s < SETS; s++)
                  mem[a][w][s] <= '0;
      end else if (we) begin
         mem[w_arr][w_way][w_set] <= din;
      end
   end

   assign dout = mem[r_arr][r_way][r_set];

   // A slot changes only in the cycle after its own enable (R3, R4).
   for (genvar ga = 0; ga < N_ARR; ga++) begin : g_a
      for (genvar gw = 0; gw < MAX_WAYS; gw++) begin : g_w
         for (genvar gs = 0; gs < SETS; gs++) begin : g_s
            p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
               !$past(we && w_arr == AIDX_W'(ga) && w_way == WAY_W'(gw) && w_set == SET_W'(gs))
               |-> $stable(mem[ga][gw][gs]));
         end
      end
   end
endmodule

// File: rtl/tlb_wr_validator.sv
module tlb_wr_validator
   import tlbw_pkg::*;
#(
   parameter int N_ARR    = 2,
   parameter int MAX_WAYS = 4,
   parameter int SETS     = 4,
   localparam int ARR_W   = $clog2(N_ARR) + 1,
   localparam int AIDX_W  = (N_ARR > 1) ? $clog2(N_ARR) : 1,
   localparam int WAY_W   = $clog2(MAX_WAYS),
   localparam int SET_W   = $clog2(SETS),
   localparam int CW      = $clog2(MAX_WAYS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_wr,
   input  logic                  cmd_rd,
   input  logic [ARR_W-1:0]      cmd_arr,
   input  logic [WAY_W-1:0]      cmd_way,
   input  logic [SET_W-1:0]      cmd_set,
   input  logic                  stg_valid,
   input  logic [3:0]            stg_size,
   input  logic [7:0]            stg_tid,
   input  logic [63:0]           stg_epn,
   input  logic [31:0]           stg_ra_hi,
   input  logic [31:0]           stg_ra_lo,
   input  logic [N_ARR*CW-1:0]   cfg_ways,
   input  logic [N_ARR-1:0]      cfg_var,
   input  logic [N_ARR*16-1:0]   cfg_sizes,
   input  logic [N_ARR*4-1:0]    cfg_min,
   output logic                  wr_done,
   output logic                  wr_exc,
   output logic                  rd_valid,
   output logic                  rd_vbit,
   output logic [3:0]            rd_size,
   output logic [7:0]            rd_tid,
   output logic [31:0]           rd_epn,
   output logic [63:0]           rd_ra
);
   initial begin
      if (N_ARR < 2 || MAX_WAYS < 2 || SETS < 2)
         $error("tlb_wr_validator: N_ARR, MAX_WAYS and SETS must each be at least 2");
      if (SZ_W != 4 || TID_W != 8)
         $error("tlb_wr_validator: entry format does not match port widths");
   end

   // Configuration row of the addressed array
   logic             sel_var;
   logic [MAP_W-1:0] sel_map;
   logic [SZ_W-1:0]  sel_min;

   always_comb begin
      sel_var = 1'b0;
      sel_map = '0;
      sel_min = '0;
      for (int i = 0; i < N_ARR; i++) begin
         if (cmd_arr == ARR_W'(i)) begin
            sel_var = cfg_var[i];
            sel_map = cfg_sizes[i*MAP_W +: MAP_W];
            sel_min = cfg_min[i*SZ_W +: SZ_W];
         end
      end
   end

   logic wr_exists, rd_exists;

   tlbw_slot_chk #(.N_ARR(N_ARR), .MAX_WAYS(MAX_WAYS)) u_wr_slot (
      .arr_i(cmd_arr), .way_i(cmd_way), .ways_cfg_i(cfg_ways), .exists_o(wr_exists));

   tlbw_slot_chk #(.N_ARR(N_ARR), .MAX_WAYS(MAX_WAYS)) u_rd_slot (
      .arr_i(cmd_arr), .way_i(cmd_way), .ways_cfg_i(cfg_ways), .exists_o(rd_exists));

   logic            size_ok;
   logic [SZ_W-1:0] size_fin;

   tlbw_size_ctl u_size (
      .vld_i(stg_valid), .var_i(sel_var), .map_i(sel_map), .min_i(sel_min),
      .size_i(stg_size), .ok_o(size_ok), .size_o(size_fin));

   logic        wr_go, wr_bad;
   tlbw_entry_t new_ent, cur_ent;
   logic [31:0] unused_epn_hi;

   assign wr_go  = cmd_wr && wr_exists && size_ok;
   assign wr_bad = cmd_wr && !(wr_exists && size_ok);
   assign unused_epn_hi = stg_epn[63:32];

   always_comb begin
      new_ent.vld  = stg_valid;
      new_ent.size = size_fin;
      new_ent.tid  = stg_tid;
      new_ent.epn  = stg_epn[EPN_W-1:0];
      new_ent.ra   = {stg_ra_hi, stg_ra_lo};
   end

   tlbw_store #(.N_ARR(N_ARR), .MAX_WAYS(MAX_WAYS), .SETS(SETS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(wr_go), .w_arr(cmd_arr[AIDX_W-1:0]), .w_way(cmd_way), .w_set(cmd_set),
      .din(new_ent),
      .r_arr(cmd_arr[AIDX_W-1:0]), .r_way(cmd_way), .r_set(cmd_set),
      .dout(cur_ent));

   tlbw_entry_t rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_done  <= 1'b0;
         wr_exc   <= 1'b0;
         rd_valid <= 1'b0;
         rd_q     <= '0;
      end else begin
         wr_done  <= wr_go;
         wr_exc   <= wr_bad;
         rd_valid <= cmd_rd;
         if (cmd_rd)
            rd_q <= rd_exists ? cur_ent : '0;
      end
   end

   assign rd_vbit = rd_q.vld;
   assign rd_size = rd_q.size;
   assign rd_tid  = rd_q.tid;
   assign rd_epn  = rd_q.epn;
   assign rd_ra   = rd_q.ra;

   p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> $past(cmd_wr));
   p_exc_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_exc |-> $past(cmd_wr));
   p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_done && wr_exc));
   p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_rd) && !$past(rd_exists)) |-> (rd_q == '0));
endmodule

// File: tb/tlb_wr_validator_test.sv
module tlb_wr_validator_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        cmd_wr = 0, cmd_rd = 0;
   logic [1:0]  cmd_arr = 0, cmd_way = 0, cmd_set = 0;
   logic        stg_valid = 0;
   logic [3:0]  stg_size = 0;
   logic [7:0]  stg_tid = 0;
   logic [63:0] stg_epn = 0;
   logic [31:0] stg_ra_hi = 0, stg_ra_lo = 0;
   // array 0: 4 ways, variable, bitmap 0A5A, min 1; array 1: 2 ways, fixed, min 5
   logic [5:0]  cfg_ways  = {3'd2, 3'd4};
   logic [1:0]  cfg_var   = 2'b01;
   logic [31:0] cfg_sizes = {16'h0000, 16'h0A5A};
   logic [7:0]  cfg_min   = {4'd5, 4'd1};
   logic        wr_done, wr_exc, rd_valid, rd_vbit;
   logic [3:0]  rd_size;
   logic [7:0]  rd_tid;
   logic [31:0] rd_epn;
   logic [63:0] rd_ra;

   tlb_wr_validator uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
      .cmd_arr(cmd_arr), .cmd_way(cmd_way), .cmd_set(cmd_set),
      .stg_valid(stg_valid), .stg_size(stg_size), .stg_tid(stg_tid),
      .stg_epn(stg_epn), .stg_ra_hi(stg_ra_hi), .stg_ra_lo(stg_ra_lo),
      .cfg_ways(cfg_ways), .cfg_var(cfg_var), .cfg_sizes(cfg_sizes), .cfg_min(cfg_min),
      .wr_done(wr_done), .wr_exc(wr_exc), .rd_valid(rd_valid), .rd_vbit(rd_vbit),
      .rd_size(rd_size), .rd_tid(rd_tid), .rd_epn(rd_epn), .rd_ra(rd_ra));

   int total = 0, bad = 0;

   // bench model of stored entries: {vld, size, tid, epn, ra} = 109 bits
   logic [108:0] model [2][4][4];

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic bit slot_ok(input logic [1:0] a, input logic [1:0] w);
      return (a == 0) || (a == 1 && w < 2);
   endfunction

   task automatic rd_chk(input logic [1:0] a, input logic [1:0] w, input logic [1:0] s,
                         input string tag);
      logic [108:0] exp;
      @(negedge clk);
      cmd_rd = 1; cmd_arr = a; cmd_way = w; cmd_set = s;
      @(posedge clk); #1;
      exp = slot_ok(a, w) ? model[a[0]][w][s] : '0;
      chk({tag, " R9 rd_valid"}, 128'(rd_valid), 128'(1));
      chk(tag, 128'({rd_vbit, rd_size, rd_tid, rd_epn, rd_ra}), 128'(exp));
      @(negedge clk);
      cmd_rd = 0;
   endtask

   // {exp_exc, arr, way, set, valid, size}
   localparam logic [11:0] VEC [12] = '{
      {1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd1},
      {1'b1, 2'd0, 2'd1, 2'd2, 1'b1, 4'd2},
      {1'b0, 2'd0, 2'd3, 2'd3, 1'b1, 4'd11},
      {1'b0, 2'd0, 2'd2, 2'd1, 1'b0, 4'd2},
      {1'b0, 2'd1, 2'd0, 2'd0, 1'b1, 4'd9},
      {1'b0, 2'd1, 2'd1, 2'd3, 1'b1, 4'd0},
      {1'b1, 2'd1, 2'd2, 2'd0, 1'b1, 4'd1},
      {1'b1, 2'd2, 2'd0, 2'd0, 1'b1, 4'd1},
      {1'b1, 2'd3, 2'd3, 2'd3, 1'b0, 4'd1},
      {1'b1, 2'd0, 2'd0, 2'd0, 1'b1, 4'd15},
      {1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 4'd4},
      {1'b0, 2'd0, 2'd1, 2'd2, 1'b1, 4'd6}
   };

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int a = 0; a < 2; a++)
         for (int w = 0; w < 4; w++)
            for (int s = 0; s < 4; s++)
               model[a][w][s] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1 outputs idle", 128'({wr_done, wr_exc, rd_valid}), 128'(0));
      rd_chk(2'd0, 2'd3, 2'd3, "R1 reset entry a0");
      rd_chk(2'd1, 2'd1, 2'd2, "R1 reset entry a1");

      for (int i = 0; i < 12; i++) begin
         logic [11:0]  v;
         logic [108:0] ent;
         v = VEC[i];
         @(negedge clk);
         cmd_wr = 1; cmd_arr = v[10:9]; cmd_way = v[8:7]; cmd_set = v[6:5];
         stg_valid = v[4]; stg_size = v[3:0];
         stg_tid = 8'(i * 17 + 3);
         stg_epn = {32'hDEAD_0000 + 32'(i), 32'h1000_0000 + 32'(i << 12)};
         stg_ra_hi = 32'hA000_0000 | 32'(i);
         stg_ra_lo = 32'h0000_5000 + 32'(i);
         @(posedge clk); #1;
         chk($sformatf("R2/R3/R4 vec %0d done,exc", i),
             128'({wr_done, wr_exc}), 128'({~v[11], v[11]}));
         // R6: fixed-size array stores its minimum; R7/R8 packing
         ent = {v[4], (v[10:9] == 2'd1) ? 4'd5 : v[3:0], stg_tid,
                stg_epn[31:0], stg_ra_hi, stg_ra_lo};
         if (!v[11]) model[v[9]][v[8:7]][v[6:5]] = ent;
         @(negedge clk);
         cmd_wr = 0;
         @(posedge clk); #1;
         chk($sformatf("R11 vec %0d pulse ends", i), 128'({wr_done, wr_exc}), 128'(0));
         rd_chk(v[10:9], v[8:7], v[6:5], $sformatf("R7 R8 R5 R6 vec %0d readback", i));
      end

      // R4: rejected size left entry a0 w0 s0 as written by the last good write
      rd_chk(2'd0, 2'd0, 2'd0, "R4 entry kept");
      // R3: nonexistent way of array 1 did not alias into way 0 or way 2 storage
      rd_chk(2'd1, 2'd0, 2'd0, "R3 neighbour kept");
      rd_chk(2'd0, 2'd3, 2'd3, "R3 aliased slot kept");
      // R10: reads of missing slots are zero
      rd_chk(2'd1, 2'd3, 2'd3, "R10 missing way");
      rd_chk(2'd3, 2'd0, 2'd0, "R10 missing array");

      // R11: back-to-back bad then good write
      @(negedge clk);
      cmd_wr = 1; cmd_arr = 2'd0; cmd_way = 2'd2; cmd_set = 2'd2;
      stg_valid = 1; stg_size = 4'd0;
      @(posedge clk); #1;
      chk("R11 b2b first exc", 128'({wr_done, wr_exc}), 128'(2'b01));
      @(negedge clk);
      stg_size = 4'd3;
      @(posedge clk); #1;
      chk("R11 b2b second done", 128'({wr_done, wr_exc}), 128'(2'b10));
      model[0][2][2] = {1'b1, 4'd3, stg_tid, stg_epn[31:0], stg_ra_hi, stg_ra_lo};
      @(negedge clk);
      cmd_wr = 0;
      rd_chk(2'd0, 2'd2, 2'd2, "R11 b2b readback");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule